// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Pipelined Serial Readout

This block is the digital half of an isolated 12-bit successive-approximation converter. A falling edge on the active-low read/convert input `rc_n` starts a conversion, provided the block is not already busy. The block then drops `busy` and walks a trial code from the most significant bit down to the least significant bit. An external DAC turns `trial_code` into a voltage, and an external comparator reports on `cmp_in` whether the sampled input lies at or above that voltage. Once the last bit is decided, the code is latched as the held result and `busy` returns high.

The start of conversion n also loads the held result of conversion n−1 into a serial shifter. That word goes out on `sdata`, MSB first, clocked by a data clock `dclk` that the block derives from the system clock. `fmt_sb` is sampled when the word is loaded. A high level selects straight binary. A low level selects two's complement, which is the same word with its MSB inverted.

The converter FSM has three states. In CV_IDLE `busy` is high. The transition *start* leads to CV_SETTLE. CV_SETTLE holds each trial bit for `STEP_DIV` cycles. The transition *next_bit* stays in CV_SETTLE, and the transition *last_bit* leads to CV_DONE. CV_DONE latches the result, and the transition *finish* leads back to CV_IDLE.

The shifter FSM has three states: SH_IDLE, SH_LOW and SH_HIGH. The transition *load* leads from any state to SH_LOW. The transition *rise* leads from SH_LOW to SH_HIGH. The transition *fall* leads from SH_HIGH back to SH_LOW while bits remain. The transition *drain* leads from SH_HIGH to SH_IDLE after the final bit.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion starts only on a clock in which `rc_n` is low, `rc_n` was high in the previous clock, and `busy` is high. A held low level does not start one, and a falling edge while `busy` is low is ignored: the running conversion keeps its length and its result.
- R2: `busy` goes low in the clock after the start edge. It stays low for exactly `N_BITS*STEP_DIV+1` clocks and then returns high.
- R3: The bit trials run from bit N_BITS−1 down to bit 0. Each trial bit is set, held for `STEP_DIV` clocks, and kept only if `cmp_in` is high in the last of those clocks (`cmp_in` high means the input is at or above the trial level). At completion `trial_code` equals the converged code, and that code becomes the held result.
- R4: During conversion n, the held result of conversion n−1 is shifted out MSB first on `sdata`. Exactly N_BITS rising edges of `dclk` occur, one bit per rising edge.
- R5: The format is sampled when the word is loaded. With `fmt_sb`=1 the word is sent unchanged (straight binary). With `fmt_sb`=0 its MSB is inverted (two's complement). For 12 bits: FFF→7FF, 800→000, 000→800.
- R6: `sdata` changes only while `dclk` is low and is steady through every high phase.
- R7: `dclk` is low for `DCLK_HALF` clocks after the start edge, then rises. Each phase lasts `DCLK_HALF` clocks.
- R8: With no bits pending, `dclk` and `sdata` are both low.
- R9: After reset, `busy` is high, `trial_code` is zero, the held result is zero, and `dclk`/`sdata` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_n | input | 1 | Read/convert; falling edge starts a conversion |
| fmt_sb | input | 1 | 1 = straight binary, 0 = two's complement |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| busy | output | 1 | High when idle, low during conversion |
| trial_code | output | N_BITS | Trial code driven to the DAC |
| dclk | output | 1 | Generated serial data clock |
| sdata | output | 1 | Serial data of the previous result |

## Verification
The bench builds the block with N_BITS=12, STEP_DIV=4 and DCLK_HALF=2. With these values a conversion takes 49 clocks and the readout takes 48 clocks, so hundreds of conversions fit in the run. The bench sweeps target codes across the whole 12-bit range in steps of 13 and adds the full-scale, midscale and near-zero corner codes in both formats. A behavioural comparator answers each trial from the target code, so every converted result must match its target exactly. Every result is then checked again, in the chosen format, when it comes out during the following conversion. Some conversions carry an extra falling edge of `rc_n` while `busy` is low, which exercises the case where that edge must be ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        CV_IDLE   = 2'd0,
        CV_SETTLE = 2'd1,
        CV_DONE   = 2'd2
    } conv_state_t;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } shift_state_t;

endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_n,
    input  logic armed,
    output logic start
);
    logic rc_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_prev <= 1'b1;
        end else begin
            rc_prev <= rc_n;
        end
    end

    // Falling edge qualified by the idle flag
    always_comb begin
        start = armed & rc_prev & ~rc_n;
    end

    // R1: a start drops busy, so no second start can follow directly
    a_r1_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/sar_seq_conv.sv
module sar_seq_conv
    import sar_seq_pkg::*;
#(
    parameter int N_BITS   = 12,
    parameter int STEP_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_in,
    output logic              busy,
    output logic [N_BITS-1:0] trial_code,
    output logic [N_BITS-1:0] result
);
    localparam int IDX_W = (N_BITS > 1) ? $clog2(N_BITS) : 1;
    localparam int CNT_W = $clog2(STEP_DIV + 1);

    conv_state_t       state, state_nxt;
    logic [N_BITS-1:0] code, code_nxt, low_mask;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt;
    logic              last_tick;

    always_comb begin
        last_tick = (cnt == CNT_W'(STEP_DIV - 1));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CV_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: start, next_bit, last_bit, finish
    always_comb begin
        state_nxt = state;
        unique case (state)
            CV_IDLE:   if (start) state_nxt = CV_SETTLE;
            CV_SETTLE: if (last_tick && idx == '0) state_nxt = CV_DONE;
            CV_DONE:   state_nxt = CV_IDLE;
            default:   state_nxt = CV_IDLE;
        endcase
    end

    // Decision on the current bit and arming of the next lower bit
    always_comb begin
        code_nxt      = code;
        code_nxt[idx] = cmp_in;
        if (idx != '0) begin
            code_nxt[idx - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code   <= '0;
            idx    <= '0;
            cnt    <= '0;
            result <= '0;
        end else begin
            unique case (state)
                CV_IDLE: begin
                    if (start) begin
                        code <= {1'b1, {(N_BITS-1){1'b0}}};
                        idx  <= IDX_W'(N_BITS - 1);
                        cnt  <= '0;
                    end
                end
                CV_SETTLE: begin
                    if (last_tick) begin
                        cnt  <= '0;
                        code <= code_nxt;
                        if (idx != '0) begin
                            idx <= idx - 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CV_DONE: begin
                    result <= code;
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state == CV_IDLE);
        trial_code = code;
    end

    always_comb begin
        low_mask = (N_BITS'(1) << idx) - N_BITS'(1);
    end

    // R1: starts come from the edge detector only when idle
    a_r1_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == CV_IDLE);

    // R3: the bit index never climbs inside one conversion
    a_r3_index_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CV_SETTLE && $past(state) == CV_SETTLE) |-> idx <= $past(idx));

    // R3: bits below the one on trial are still clear
    a_r3_lower_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        state == CV_SETTLE |-> (code & low_mask) == '0);

    // R3: the held result only moves on completion
    a_r3_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(state) == CV_DONE);

    // R2: busy rises only out of the completion state
    a_r2_busy_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state) == CV_DONE);

endmodule

// File: rtl/sar_seq_shift.sv
module sar_seq_shift
    import sar_seq_pkg::*;
#(
    parameter int N_BITS    = 12,
    parameter int DCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fmt_sb,
    input  logic [N_BITS-1:0] word_in,
    output logic              dclk,
    output logic              sdata
);
    localparam int CNT_W  = $clog2(DCLK_HALF + 1);
    localparam int LEFT_W = $clog2(N_BITS + 1);

    shift_state_t      state, state_nxt;
    logic [N_BITS-1:0] sreg, word_fmt;
    logic [CNT_W-1:0]  cnt;
    logic [LEFT_W-1:0] bits_left;
    logic              half_done;

    always_comb begin
        half_done = (cnt == CNT_W'(DCLK_HALF - 1));
        word_fmt  = {word_in[N_BITS-1] ^ ~fmt_sb, word_in[N_BITS-2:0]};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: load, rise, fall, drain
    always_comb begin
        state_nxt = state;
        if (load) begin
            state_nxt = SH_LOW;
        end else begin
            unique case (state)
                SH_IDLE: state_nxt = SH_IDLE;
                SH_LOW:  if (half_done) state_nxt = SH_HIGH;
                SH_HIGH: if (half_done) state_nxt = (bits_left > LEFT_W'(1)) ? SH_LOW : SH_IDLE;
                default: state_nxt = SH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg      <= '0;
            cnt       <= '0;
            bits_left <= '0;
        end else if (load) begin
            sreg      <= word_fmt;
            cnt       <= '0;
            bits_left <= LEFT_W'(N_BITS);
        end else begin
            unique case (state)
                SH_IDLE: begin
                    cnt <= '0;
                end
                SH_LOW: begin
                    cnt <= half_done ? '0 : cnt + 1'b1;
                end
                SH_HIGH: begin
                    if (half_done) begin
                        cnt       <= '0;
                        sreg      <= sreg << 1;
                        bits_left <= bits_left - 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        dclk  = (state == SH_HIGH);
        sdata = (state != SH_IDLE) & sreg[N_BITS-1];
    end

    // R6: data held across the whole high phase
    a_r6_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(sdata));

    // R6: any data change lands in a low phase
    a_r6_change_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> !dclk);

    // R4: a rising data clock always has a bit behind it
    a_r4_rise_has_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk) |-> bits_left != '0);

    // R4: pending count never exceeds one word
    a_r4_pending_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bits_left <= LEFT_W'(N_BITS));

    // R8: nothing pending means a quiet line after the last bit
    a_r8_quiet_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_left == '0 && !load) |=> (!dclk && !sdata));

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int N_BITS    = 12,
    parameter int STEP_DIV  = 16,
    parameter int DCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rc_n,
    input  logic              fmt_sb,
    input  logic              cmp_in,
    output logic              busy,
    output logic [N_BITS-1:0] trial_code,
    output logic              dclk,
    output logic              sdata
);
    logic              start;
    logic              busy_w;
    logic [N_BITS-1:0] held;

    sar_seq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rc_n  (rc_n),
        .armed (busy_w),
        .start (start)
    );

    sar_seq_conv #(
        .N_BITS   (N_BITS),
        .STEP_DIV (STEP_DIV)
    ) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmp_in     (cmp_in),
        .busy       (busy_w),
        .trial_code (trial_code),
        .result     (held)
    );

    sar_seq_shift #(
        .N_BITS    (N_BITS),
        .DCLK_HALF (DCLK_HALF)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .fmt_sb  (fmt_sb),
        .word_in (held),
        .dclk    (dclk),
        .sdata   (sdata)
    );

    always_comb begin
        busy = busy_w;
    end

    // R2: busy drops in the clock after a qualifying start
    a_r2_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !busy);

    // R7: the data clock stays low in the clock after a load
    a_r7_low_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !dclk);

endmodule

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;
    localparam int NB   = 12;
    localparam int STEP = 4;
    localparam int HALF = 2;
    localparam int CONV_LEN = NB * STEP + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rc_n = 1'b1;
    logic          fmt_sb = 1'b1;
    logic          cmp_in;
    logic          busy;
    logic [NB-1:0] trial_code;
    logic          dclk;
    logic          sdata;
    logic [NB-1:0] tgt = '0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sar_seq_top #(.N_BITS(NB), .STEP_DIV(STEP), .DCLK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .fmt_sb(fmt_sb), .cmp_in(cmp_in),
        .busy(busy), .trial_code(trial_code), .dclk(dclk), .sdata(sdata)
    );

    // Behavioural comparator: input at or above the trial level
    always_comb cmp_in = (tgt >= trial_code);

    // Serial monitor, sampling on falling system-clock edges
    logic          prev_dclk = 1'b0, prev_busy = 1'b1, prev_sdata = 1'b0;
    int            lowcnt = 0, pulses = 0, first_rise = 0, high_changes = 0;
    logic [NB-1:0] cap = '0;

    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            lowcnt = 1; pulses = 0; first_rise = 0; cap = '0;
        end else if (!busy) begin
            lowcnt = lowcnt + 1;
        end
        if (dclk && !prev_dclk) begin
            if (pulses == 0) first_rise = lowcnt;
            pulses = pulses + 1;
            cap = {cap[NB-2:0], sdata};
        end
        if (dclk && prev_dclk && sdata != prev_sdata) high_changes = high_changes + 1;
        prev_dclk = dclk; prev_busy = busy; prev_sdata = sdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [NB-1:0] prev_res = '0;

    task automatic do_conv(input logic [NB-1:0] t, input logic f, input logic glitch);
        logic [NB-1:0] exp_word;
        int n;
        tgt = t; fmt_sb = f;
        @(negedge clk); rc_n = 1'b0;
        @(negedge clk); #1;
        chk("R2 busy low after start", busy, 0);
        n = 0;
        while (busy == 1'b0 && n < 1000) begin
            if (glitch && n == 10) rc_n = 1'b1;
            if (glitch && n == 11) rc_n = 1'b0;
            @(negedge clk); #1;
            n++;
        end
        chk("R2 busy low length", lowcnt, CONV_LEN);
        chk("R3 converged code", trial_code, t);
        if (glitch) chk("R1 edge during busy ignored", trial_code, t);
        chk("R4 pulse count", pulses, NB);
        exp_word = f ? prev_res : (prev_res ^ {1'b1, {(NB-1){1'b0}}});
        chk("R5 serial word of previous result", cap, exp_word);
        chk("R7 first rise delay", first_rise, HALF + 1);
        chk("R6 data steady while high", high_changes, 0);
        chk("R8 idle dclk low", dclk, 0);
        chk("R8 idle sdata low", sdata, 0);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 held low level no start", busy, 1);
        rc_n = 1'b1;
        @(negedge clk);
        prev_res = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9 busy after reset", busy, 1);
        chk("R9 trial after reset", trial_code, 0);
        chk("R9 dclk after reset", dclk, 0);
        chk("R9 sdata after reset", sdata, 0);
        // First conversion reads out the zero reset result
        do_conv(12'hFFF, 1'b0, 1'b0);   // R9: shifts out 800 (zero in two's complement)
        // R5 corner formats
        do_conv(12'h800, 1'b0, 1'b0);   // previous FFF -> 7FF
        do_conv(12'h000, 1'b1, 1'b0);   // previous 800 -> 800
        do_conv(12'hFFF, 1'b0, 1'b1);   // previous 000 -> 800
        do_conv(12'h7FF, 1'b1, 1'b0);   // previous FFF -> FFF
        do_conv(12'h001, 1'b0, 1'b0);
        do_conv(12'hFFE, 1'b1, 1'b1);
        for (int t = 0; t < 4096; t += 13) begin
            do_conv(t[NB-1:0], t[1], (t % 5) == 0);
        end
        do_conv(12'h000, 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule